// File: doc/BRIEF.md
# Dead-Time Correction Selector

This block decides, for each complementary PWM output pair, whether the pair's duty comes from its even-numbered or its odd-numbered value register during the coming PWM period. The choice compensates the distortion introduced by dead time, and it can come from software, from a current-status pin sampled while both switches of the pair are off, or from a current-status pin sampled at a fixed point of the period.

The PWM counter, comparators, dead-time generation and fault logic sit elsewhere; the block sees them only through a period-boundary strobe, a half-period strobe, the alignment mode and the live top/bottom gate states. Software writes a buffered polarity word and can read it back at any time. Every change of selection is deferred to the next period boundary, so a pair never swaps value registers part way through a period.

Top module: `deadtime_corr_sel`

## Requirements
- R1: After a synchronous active-low reset, `val_sel` and `pol_rdback` are all zero, and the held sample of every pair is zero.
- R2: A cycle with `pol_wr_en` high stores `pol_wr_data` in the buffered polarity word; `pol_rdback` shows it from the next cycle, while `val_sel` keeps its value until a period boundary.
- R3: With `method_sel` = 2'b01 (software correction), a cycle with `cyc_stb` high copies the buffered polarity word into the active selection; no other enable is needed.
- R4: With `method_sel` not 2'b00, `val_sel` changes only in the cycle after a `cyc_stb` pulse.
- R5: With `method_sel` = 2'b00 (correction off), every bit of `val_sel` is 0 and the current-status pins and gate states have no effect on it.
- R6: Bit n of `val_sel` selects value register 2n when 0 and value register 2n+1 when 1, for pair n from 0 to NUM_PAIRS-1.
- R7: With `method_sel` = 2'b10 (dead-time sampling), pair n records its synchronized pin on every cycle in which `gate_top[n]` and `gate_bot[n]` are both 0, and holds the record in any cycle in which either is 1, so at 0% or 100% duty the previous selection persists.
- R8: With `method_sel` = 2'b11 (period sampling), every pair records its synchronized pin on `half_stb` when `center_mode` is 1 and on `cyc_stb` when `center_mode` is 0, whatever the gate states; it records nothing in other cycles.
- R9: In modes 2'b10 and 2'b11, a `cyc_stb` cycle copies the record held before that edge into the active selection; in edge-aligned period sampling the value taken at one boundary therefore reaches `val_sel` at the following boundary.
- R10: Each current-status pin passes through a two-flop synchronizer: a record taken at a clock edge holds the pin level that was present two edges earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| method_sel | input | 2 | Correction method: 00 off, 01 software, 10 dead-time sampling, 11 period sampling |
| pol_wr_en | input | 1 | Write strobe for the buffered polarity word |
| pol_wr_data | input | NUM_PAIRS | Polarity word written by software |
| cs_pin | input | NUM_PAIRS | Asynchronous current-status pins, one per pair |
| gate_top | input | NUM_PAIRS | Top switch state per pair, 1 = on |
| gate_bot | input | NUM_PAIRS | Bottom switch state per pair, 1 = on |
| center_mode | input | 1 | 1 = center-aligned counting, 0 = edge-aligned |
| cyc_stb | input | 1 | One-cycle pulse at the period boundary (start of the next load cycle) |
| half_stb | input | 1 | One-cycle pulse at the half-period point |
| val_sel | output | NUM_PAIRS | Per-pair value register select, 0 = even, 1 = odd |
| pol_rdback | output | NUM_PAIRS | Buffered polarity word |

## Verification
A corrupted buffered word is visible on `pol_rdback` in the cycle after the write, while a corrupted held sample or active selection stays hidden until the next period boundary and then appears on `val_sel` for a full period. A sampler that ignores the gate states shows up only when a pin changes while one switch is on, so the stimulus moves pins under held gates and at full duty. Synchronizer depth errors shift the first boundary at which a fresh pin level appears by one cycle, which the bench hits by pulsing the strobe right after a pin change. A cycle-accurate model in the bench compares both outputs on every clock.

// File: rtl/dtc_pkg.sv
// Package: shared types of the dead-time correction selector.
// Assumes: the method field is two bits wide and its encoding is fixed.
package dtc_pkg;

    typedef enum logic [1:0] {
        CORR_OFF      = 2'b00,
        CORR_SOFT     = 2'b01,
        CORR_DEADTIME = 2'b10,
        CORR_PERIOD   = 2'b11
    } corr_mode_e;

endpackage

// File: rtl/dtc_sync.sv
// Module: dtc_sync
// Multi-bit, multi-stage flop synchronizer for asynchronous level inputs.
// Assumes: each bit is an independent level; no bus coherency is needed.
module dtc_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop captures the raw pin level.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                // Later flops resolve metastability one stage at a time.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/dtc_pair_sampler.sv
// Module: dtc_pair_sampler
// Holds the current-status record of one output pair. In dead-time mode it
// follows the pin while both switches are off; in period mode it captures
// at the period point; otherwise it holds.
// Assumes: pin is already synchronized; period_pt is a one-cycle pulse.
module dtc_pair_sampler
    import dtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  corr_mode_e mode,
    input  logic       pin,
    input  logic       gate_top,
    input  logic       gate_bot,
    input  logic       period_pt,
    output logic       smp
);

    logic both_off;
    logic take;

    // Dead-time window: neither switch of the pair conducts.
    always_comb both_off = !gate_top && !gate_bot;

    // Decide whether this cycle records the pin.
    always_comb begin
        unique case (mode)
            CORR_DEADTIME: take = both_off;
            CORR_PERIOD:   take = period_pt;
            default:       take = 1'b0;
        endcase
    end

    // Record register, cleared by reset, updated only when take is high.
    always_ff @(posedge clk) begin
        if (!rst_n)    smp <= 1'b0;
        else if (take) smp <= pin;
    end

endmodule

// File: rtl/dtc_sel_bank.sv
// Module: dtc_sel_bank
// Buffered software polarity word and the active selection register. The
// active selection is reloaded only at the period boundary from the source
// chosen by the method.
// Assumes: load_stb is a one-cycle pulse marking the start of a load cycle.
module dtc_sel_bank
    import dtc_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  corr_mode_e           mode,
    input  logic                 wr_en,
    input  logic [NUM_PAIRS-1:0] wr_data,
    input  logic                 load_stb,
    input  logic [NUM_PAIRS-1:0] smp_vec,
    output logic [NUM_PAIRS-1:0] pol_buf,
    output logic [NUM_PAIRS-1:0] sel_q
);

    logic [NUM_PAIRS-1:0] sel_src;

    // Software-side buffer: written at any time, no load gating.
    always_ff @(posedge clk) begin
        if (!rst_n)     pol_buf <= '0;
        else if (wr_en) pol_buf <= wr_data;
    end

    // Source of the next selection for each method.
    always_comb begin
        unique case (mode)
            CORR_OFF:  sel_src = '0;
            CORR_SOFT: sel_src = pol_buf;
            default:   sel_src = smp_vec;
        endcase
    end

    // Active selection, reloaded only at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)        sel_q <= '0;
        else if (load_stb) sel_q <= sel_src;
    end

endmodule

// File: rtl/deadtime_corr_sel.sv
// Module: deadtime_corr_sel (top)
// Per-pair even/odd value register selection for dead-time distortion
// correction, with four methods: off, software, dead-time pin sampling and
// period-point pin sampling.
// Assumes: cyc_stb and half_stb are single-cycle pulses from the PWM counter;
// gate_top/gate_bot reflect the outputs after dead-time insertion.
module deadtime_corr_sel
    import dtc_pkg::*;
#(
    parameter int unsigned NUM_PAIRS   = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           method_sel,
    input  logic                 pol_wr_en,
    input  logic [NUM_PAIRS-1:0] pol_wr_data,
    input  logic [NUM_PAIRS-1:0] cs_pin,
    input  logic [NUM_PAIRS-1:0] gate_top,
    input  logic [NUM_PAIRS-1:0] gate_bot,
    input  logic                 center_mode,
    input  logic                 cyc_stb,
    input  logic                 half_stb,
    output logic [NUM_PAIRS-1:0] val_sel,
    output logic [NUM_PAIRS-1:0] pol_rdback
);

    corr_mode_e           mode;
    logic [NUM_PAIRS-1:0] cs_sync;
    logic [NUM_PAIRS-1:0] smp_vec;
    logic [NUM_PAIRS-1:0] sel_q;
    logic                 period_pt;

    // Decode the method field into the shared enum.
    always_comb mode = corr_mode_e'(method_sel);

    // Period sampling point depends on counter alignment.
    always_comb period_pt = center_mode ? half_stb : cyc_stb;

    dtc_sync #(
        .WIDTH  (NUM_PAIRS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cs_pin),
        .q     (cs_sync)
    );

    genvar p;
    generate
        for (p = 0; p < NUM_PAIRS; p++) begin : g_pair
            dtc_pair_sampler u_smp (
                .clk       (clk),
                .rst_n     (rst_n),
                .mode      (mode),
                .pin       (cs_sync[p]),
                .gate_top  (gate_top[p]),
                .gate_bot  (gate_bot[p]),
                .period_pt (period_pt),
                .smp       (smp_vec[p])
            );
        end
    endgenerate

    dtc_sel_bank #(
        .NUM_PAIRS (NUM_PAIRS)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .wr_en    (pol_wr_en),
        .wr_data  (pol_wr_data),
        .load_stb (cyc_stb),
        .smp_vec  (smp_vec),
        .pol_buf  (pol_rdback),
        .sel_q    (sel_q)
    );

    // With correction off every pair uses its even register at once.
    always_comb val_sel = (mode == CORR_OFF) ? '0 : sel_q;

endmodule

// File: rtl/dtc_checker.sv
// Module: dtc_checker
// Temporal properties of deadtime_corr_sel, attached with bind below.
// Assumes: reset is synchronous and active low.
module dtc_checker
    import dtc_pkg::*;
#(
    parameter int unsigned NP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    method_sel,
    input  logic          pol_wr_en,
    input  logic [NP-1:0] pol_wr_data,
    input  logic [NP-1:0] gate_top,
    input  logic [NP-1:0] gate_bot,
    input  logic          center_mode,
    input  logic          cyc_stb,
    input  logic          half_stb,
    input  logic [NP-1:0] pol_rdback,
    input  logic [NP-1:0] sel_q,
    input  logic [NP-1:0] smp_vec,
    input  logic [NP-1:0] cs_sync
);

    // R2: buffered word follows a write one cycle later.
    p_rdback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pol_wr_en |=> pol_rdback == $past(pol_wr_data));

    // R3: software method loads the buffered word at the boundary.
    p_soft_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && method_sel == CORR_SOFT) |=> sel_q == $past(pol_rdback));

    // R4: active selection is frozen between boundaries.
    p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_stb |=> $stable(sel_q));

    // R5: a boundary with correction off clears the active selection.
    p_off_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && method_sel == CORR_OFF) |=> sel_q == '0);

    // R7: no record changes for a pair whose switch is on.
    p_dt_gate_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (method_sel == CORR_DEADTIME) |=>
            ((smp_vec ^ $past(smp_vec)) & $past(gate_top | gate_bot)) == '0);

    // R8: period method records the synchronized pins at the period point.
    p_period_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (method_sel == CORR_PERIOD && (center_mode ? half_stb : cyc_stb))
            |=> smp_vec == $past(cs_sync));

    // R8: period method records nothing away from the period point.
    p_period_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (method_sel == CORR_PERIOD && !(center_mode ? half_stb : cyc_stb))
            |=> $stable(smp_vec));

    // R9: sampling methods load the record held before the boundary.
    p_smp_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && method_sel[1]) |=> sel_q == $past(smp_vec));

endmodule

bind deadtime_corr_sel dtc_checker #(.NP(NUM_PAIRS)) u_dtc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .method_sel  (method_sel),
    .pol_wr_en   (pol_wr_en),
    .pol_wr_data (pol_wr_data),
    .gate_top    (gate_top),
    .gate_bot    (gate_bot),
    .center_mode (center_mode),
    .cyc_stb     (cyc_stb),
    .half_stb    (half_stb),
    .pol_rdback  (pol_rdback),
    .sel_q       (sel_q),
    .smp_vec     (smp_vec),
    .cs_sync     (cs_sync)
);

// File: tb/tb_deadtime_corr_sel.sv
module tb_deadtime_corr_sel;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    method_sel = 2'b00;
    logic          pol_wr_en = 1'b0;
    logic [NP-1:0] pol_wr_data = '0;
    logic [NP-1:0] cs_pin = '0;
    logic [NP-1:0] gate_top = '0;
    logic [NP-1:0] gate_bot = '0;
    logic          center_mode = 1'b0;
    logic          cyc_stb = 1'b0;
    logic          half_stb = 1'b0;
    logic [NP-1:0] val_sel;
    logic [NP-1:0] pol_rdback;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    deadtime_corr_sel #(.NUM_PAIRS(NP), .SYNC_STAGES(2)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .method_sel  (method_sel),
        .pol_wr_en   (pol_wr_en),
        .pol_wr_data (pol_wr_data),
        .cs_pin      (cs_pin),
        .gate_top    (gate_top),
        .gate_bot    (gate_bot),
        .center_mode (center_mode),
        .cyc_stb     (cyc_stb),
        .half_stb    (half_stb),
        .val_sel     (val_sel),
        .pol_rdback  (pol_rdback)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state (behavioural).
    logic [NP-1:0] pin_hist[$];
    logic [NP-1:0] m_smp = '0;
    logic [NP-1:0] m_sel = '0;
    logic [NP-1:0] m_pol = '0;

    task automatic check(input string req, input logic [NP-1:0] act,
                         input logic [NP-1:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Model update at each rising edge, comparison a quarter period later.
    always begin
        logic [NP-1:0] seen;
        logic [NP-1:0] n_smp;
        @(posedge clk);
        if (!rst_n) begin
            pin_hist = '{'0, '0};
            m_smp = '0; m_sel = '0; m_pol = '0;
        end else begin
            seen  = pin_hist[0];
            n_smp = m_smp;
            for (int k = 0; k < NP; k++) begin
                if (method_sel == 2'b10 && !gate_top[k] && !gate_bot[k]) n_smp[k] = seen[k];
                if (method_sel == 2'b11 && (center_mode ? half_stb : cyc_stb)) n_smp[k] = seen[k];
            end
            if (cyc_stb) begin
                if (method_sel == 2'b00)      m_sel = '0;
                else if (method_sel == 2'b01) m_sel = m_pol;
                else                          m_sel = m_smp;
            end
            if (pol_wr_en) m_pol = pol_wr_data;
            m_smp = n_smp;
            pin_hist.push_back(cs_pin);
            void'(pin_hist.pop_front());
        end
        #(CLK_PERIOD/4);
        check(cur_req, val_sel, (method_sel == 2'b00) ? '0 : m_sel, "val_sel model");
        check("R2", pol_rdback, m_pol, "pol_rdback model");
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_cyc();
        @(negedge clk) cyc_stb = 1'b1;
        @(negedge clk) cyc_stb = 1'b0;
    endtask

    task automatic pulse_half();
        @(negedge clk) half_stb = 1'b1;
        @(negedge clk) half_stb = 1'b0;
    endtask

    task automatic write_pol(input logic [NP-1:0] v);
        @(negedge clk) begin pol_wr_en = 1'b1; pol_wr_data = v; end
        @(negedge clk) pol_wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        idle(3);
        check("R1", val_sel, 3'b000, "val_sel after reset");
        check("R1", pol_rdback, 3'b000, "pol_rdback after reset");
        @(negedge clk) rst_n = 1'b1;

        // R2: buffered write visible on readback only
        cur_req = "R2";
        method_sel = 2'b01;
        write_pol(3'b101);
        check("R2", pol_rdback, 3'b101, "readback after write");
        idle(3);
        check("R2", val_sel, 3'b000, "val_sel before boundary");

        // R3 / R6: software word applied at boundary, per-pair bits
        cur_req = "R3";
        pulse_cyc();
        check("R3", val_sel, 3'b101, "soft load");
        write_pol(3'b010);
        check("R4", val_sel, 3'b101, "no change mid-period");
        pulse_cyc();
        check("R6", val_sel, 3'b010, "pair 1 odd, pairs 0 and 2 even");

        // R5: correction off ignores pins
        cur_req = "R5";
        @(negedge clk) begin method_sel = 2'b00; cs_pin = 3'b111; end
        idle(4);
        check("R5", val_sel, 3'b000, "off before boundary");
        pulse_cyc();
        check("R5", val_sel, 3'b000, "off after boundary");

        // R7: dead-time sampling
        cur_req = "R7";
        @(negedge clk) begin method_sel = 2'b10; cs_pin = 3'b110; end
        idle(4);
        pulse_cyc();
        check("R7", val_sel, 3'b110, "dead-time sample applied");
        @(negedge clk) begin gate_top = 3'b010; cs_pin = 3'b000; end
        idle(4);
        pulse_cyc();
        check("R7", val_sel, 3'b010, "pair with gate on holds");
        @(negedge clk) begin gate_top = 3'b111; cs_pin = 3'b101; end
        idle(4);
        pulse_cyc();
        pulse_cyc();
        check("R7", val_sel, 3'b010, "full duty holds previous");

        // R8 / R9: period sampling, center aligned
        cur_req = "R8";
        @(negedge clk) begin method_sel = 2'b11; center_mode = 1'b1; cs_pin = 3'b011; end
        idle(3);
        pulse_half();
        @(negedge clk) cs_pin = 3'b100;
        idle(3);
        pulse_cyc();
        check("R8", val_sel, 3'b011, "center: half-point sample");

        // R9: edge aligned, one boundary of latency
        cur_req = "R9";
        @(negedge clk) begin center_mode = 1'b0; cs_pin = 3'b101; end
        idle(3);
        pulse_cyc();
        check("R9", val_sel, 3'b011, "edge: previous record applied");
        pulse_cyc();
        check("R9", val_sel, 3'b101, "edge: new record applied");

        // R8: gate states irrelevant in period mode
        @(negedge clk) begin gate_top = 3'b111; gate_bot = 3'b000; cs_pin = 3'b010; end
        idle(3);
        pulse_cyc();
        pulse_cyc();
        check("R8", val_sel, 3'b010, "period sampling at full duty");

        // R10: synchronizer latency
        cur_req = "R10";
        @(negedge clk) begin cs_pin = 3'b101; cyc_stb = 1'b1; end
        @(negedge clk) cyc_stb = 1'b0;
        pulse_cyc();
        check("R10", val_sel, 3'b010, "fresh pin not yet synchronized");
        idle(3);
        pulse_cyc();
        pulse_cyc();
        check("R10", val_sel, 3'b101, "pin after sync delay");

        // R4: random mixed stimulus, model compared every clock
        cur_req = "R4";
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            method_sel  = 2'($urandom_range(0, 3));
            pol_wr_en   = ($urandom_range(0, 7) == 0);
            pol_wr_data = 3'($urandom);
            cs_pin      = 3'($urandom);
            gate_top    = 3'($urandom);
            gate_bot    = 3'($urandom) & ~gate_top;
            center_mode = ($urandom_range(0, 15) == 0) ? ~center_mode : center_mode;
            cyc_stb     = ($urandom_range(0, 5) == 0);
            half_stb    = !cyc_stb && ($urandom_range(0, 5) == 0);
        end
        @(negedge clk) begin cyc_stb = 1'b0; half_stb = 1'b0; pol_wr_en = 1'b0; end
        idle(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule